// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host processor a path into registers that live in a slow, always-on domain for timekeeping and power control. The remote registers do not appear in the host address map. The host sees a window of four 32-bit registers instead. It loads a remote address, a data word and a mode code that selects read or write and the byte lanes. It then starts the access by writing 1 to a control register. It polls that same register until the access has finished.

On the far side the bridge drives a request/acknowledge register bus. The request stays high, and every field stays unchanged, until the remote side acknowledges, and the remote side may take any number of cycles to do so. The busy indication clears itself on the acknowledge. On a read, the returned word is captured into the data register on that same clock edge. The staged registers are frozen while a transaction is in flight, so software that writes early cannot corrupt an access already under way.

Top module: `ibr_bridge`

## Requirements
- R1: After a synchronous reset, all four window registers read zero, busy is clear and no remote request is raised.
- R2: The register window is selected by byte offset: control at 0x0, mode at 0x4, remote address at 0x8 and data at 0xC. The mode register keeps bits 7:0 and the address register keeps the low REM_AW bits. The data register keeps all 32 bits. Bits that are not kept read as zero.
- R3: A host write of exactly 32'h1 to control while idle starts one transaction, and the remote request rises on the next clock edge. A write of any other value starts nothing.
- R4: Control reads 1 from the edge that accepts the trigger until the edge on which the acknowledge is sampled, and reads 0 afterwards. Busy therefore lasts exactly as many cycles as the remote side takes to acknowledge.
- R5: A mode value with bit 0 clear is a remote read. The write flag is driven low and all byte enables are driven low, whatever bits 7:4 hold. The data register takes the remote read data on the edge where busy clears.
- R6: A mode value with bit 0 set is a remote write. The write flag is driven high and byte enable i equals mode bit 4+i, so 0xF1 writes all four bytes. The write data is the data register, which is left unchanged by the completion.
- R7: Host writes to any of the four registers while busy is set have no effect: they start nothing and alter no staged value.
- R8: While the request is high and not yet acknowledged, the request, write flag, byte enables, address and write data hold their values. The request drops on the edge after the acknowledge is sampled.
- R9: An acknowledge that arrives while no transaction is in flight has no effect on control, data or the remote request.
- R10: The address, data and mode registers may be loaded in any order while idle, and loading them starts no transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the host and remote sides |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host register write strobe, qualified by host_we |
| host_we | input | 1 | Host write enable |
| host_addr | input | 4 | Host byte offset into the window; bits 3:2 select the register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data of the register at host_addr (combinational) |
| rem_req | output | 1 | Remote request, high while a transaction is in flight |
| rem_we | output | 1 | Remote write flag |
| rem_be | output | 4 | Remote byte enables, bit i for byte i |
| rem_addr | output | REM_AW | Remote register address |
| rem_wdata | output | 32 | Remote write data |
| rem_ack | input | 1 | Remote acknowledge, sampled while rem_req is high |
| rem_rdata | input | 32 | Remote read data, valid with rem_ack |

## Verification
The assertions check the following on every cycle. A trigger is followed by a request. A request is held until it is acknowledged and dropped right after. The remote fields stay steady across the wait. The staged mode and address registers cannot change while busy. The captured data matches the remote word on the acknowledge edge, and a write completion leaves the data register untouched. Other behaviours show only in the bench scenarios, under a remote latency swept from 1 to 16 cycles. These are the exact busy length seen by polling software, the byte-lane merge that partial writes produce in the remote store, the discarding of writes made during a transaction, and the harmlessness of a stray acknowledge while idle.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    localparam int HOST_DW  = 32;
    localparam int LANES    = HOST_DW / 8;
    localparam int MODE_W   = 4 + LANES;
    localparam int BE_LSB   = 4;
    localparam int HOST_OW  = 4;

    typedef enum logic [1:0] {
        SLOT_CTRL = 2'd0,
        SLOT_MODE = 2'd1,
        SLOT_ADDR = 2'd2,
        SLOT_DATA = 2'd3
    } slot_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic             we;
        logic [LANES-1:0] be;
    } xfer_kind_t;

    localparam logic [HOST_DW-1:0] TRIGGER_VAL = HOST_DW'(1);

    function automatic xfer_kind_t decode_mode(input logic [MODE_W-1:0] mode);
        xfer_kind_t k;
        k.we = mode[0];
        k.be = mode[0] ? mode[BE_LSB +: LANES] : '0;
        return k;
    endfunction

endpackage

// File: rtl/ibr_host_regs.sv
module ibr_host_regs
    import ibr_pkg::*;
#(
    parameter int REM_AW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_en,
    input  logic                host_we,
    input  slot_e               slot,
    input  logic [HOST_DW-1:0]  host_wdata,
    input  logic                busy,
    input  logic                cap_en,
    input  logic [HOST_DW-1:0]  cap_data,
    output logic                start,
    output logic [MODE_W-1:0]   mode_q,
    output logic [REM_AW-1:0]   addr_q,
    output logic [HOST_DW-1:0]  data_q,
    output logic [HOST_DW-1:0]  rdata
);

    logic wr_ok;
    assign wr_ok = host_en && host_we && !busy;
    assign start = wr_ok && (slot == SLOT_CTRL) && (host_wdata == TRIGGER_VAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            addr_q <= '0;
        end else if (wr_ok) begin
            if (slot == SLOT_MODE) mode_q <= host_wdata[MODE_W-1:0];
            if (slot == SLOT_ADDR) addr_q <= host_wdata[REM_AW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (cap_en) begin
            data_q <= cap_data;
        end else if (wr_ok && slot == SLOT_DATA) begin
            data_q <= host_wdata;
        end
    end

    always_comb begin
        unique case (slot)
            SLOT_CTRL: rdata = HOST_DW'(busy);
            SLOT_MODE: rdata = HOST_DW'(mode_q);
            SLOT_ADDR: rdata = HOST_DW'(addr_q);
            default:   rdata = data_q;
        endcase
    end

    // R7: staged mode and address cannot move while a transaction is in flight
    p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(mode_q) && $stable(addr_q)));

    // R5: read capture takes the remote word on the completing edge
    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (data_q == $past(cap_data)));

endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
    import ibr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rem_ack,
    input  logic is_write,
    output logic busy,
    output logic cap_en
);

    seq_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start)   state_q <= ST_WAIT;
                ST_WAIT: if (rem_ack) state_q <= ST_IDLE;
                default:              state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state_q == ST_WAIT);
    assign cap_en = busy && rem_ack && !is_write;

    // R3: an accepted trigger raises busy on the next edge
    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R4: the sampled acknowledge ends the transaction
    p_ack_ends_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && rem_ack) |=> !busy);

    // R8: busy persists until acknowledged
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !rem_ack) |=> busy);

    // R1: idle right after reset
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !busy);

endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int REM_AW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_en,
    input  logic                host_we,
    input  logic [3:0]          host_addr,
    input  logic [31:0]         host_wdata,
    output logic [31:0]         host_rdata,
    output logic                rem_req,
    output logic                rem_we,
    output logic [3:0]          rem_be,
    output logic [REM_AW-1:0]   rem_addr,
    output logic [31:0]         rem_wdata,
    input  logic                rem_ack,
    input  logic [31:0]         rem_rdata
);

    slot_e              slot;
    logic               start;
    logic               busy;
    logic               cap_en;
    logic [MODE_W-1:0]  mode_q;
    logic [HOST_DW-1:0] data_q;
    xfer_kind_t         kind;
    logic               unused_lowbits;

    assign slot           = slot_e'(host_addr[HOST_OW-1:2]);
    assign unused_lowbits = ^host_addr[1:0];
    assign kind           = decode_mode(mode_q);

    ibr_host_regs #(.REM_AW(REM_AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_en    (host_en),
        .host_we    (host_we),
        .slot       (slot),
        .host_wdata (host_wdata),
        .busy       (busy),
        .cap_en     (cap_en),
        .cap_data   (rem_rdata),
        .start      (start),
        .mode_q     (mode_q),
        .addr_q     (rem_addr),
        .data_q     (data_q),
        .rdata      (host_rdata)
    );

    ibr_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rem_ack  (rem_ack),
        .is_write (kind.we),
        .busy     (busy),
        .cap_en   (cap_en)
    );

    assign rem_req   = busy;
    assign rem_we    = kind.we;
    assign rem_be    = kind.be;
    assign rem_wdata = data_q;

    // R8: remote fields steady while waiting for acknowledge
    p_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (rem_req && !rem_ack) |=> (rem_req && $stable(rem_addr) && $stable(rem_wdata)
                                   && $stable(rem_we) && $stable(rem_be)));

    // R8: request drops right after the acknowledge
    p_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (rem_req && rem_ack) |=> !rem_req);

    // R6: write completion leaves the data register untouched
    p_write_keeps_data_r6: assert property (@(posedge clk) disable iff (rst)
        (rem_req && rem_ack && rem_we) |=> $stable(data_q));

    // R9: stray acknowledge while idle raises nothing
    p_stray_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (!rem_req && rem_ack && !start) |=> !rem_req);

endmodule

// File: tb/tb_ibr_bridge.sv
`timescale 1ns/1ps
module tb_ibr_bridge;

    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_en = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = 4'h0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        rem_req, rem_we;
    logic [3:0]  rem_be;
    logic [AW-1:0] rem_addr;
    logic [31:0] rem_wdata;
    logic        rem_ack;
    logic [31:0] rem_rdata = '0;

    logic model_ack = 1'b0;
    logic stray_ack = 1'b0;
    assign rem_ack = model_ack | stray_ack;

    always #4 clk = ~clk;

    ibr_bridge #(.REM_AW(AW)) dut (
        .clk(clk), .rst(rst), .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rem_req(rem_req), .rem_we(rem_we), .rem_be(rem_be), .rem_addr(rem_addr),
        .rem_wdata(rem_wdata), .rem_ack(rem_ack), .rem_rdata(rem_rdata)
    );

    int checks = 0;
    int fails  = 0;

    // remote responder model
    int          rem_lat = 1;
    int          cnt = 0;
    int          xfer_cnt = 0;
    logic [31:0] rmem [16];
    logic        seen_we;
    logic [3:0]  seen_be;
    logic [AW-1:0] seen_addr;
    logic [31:0] seen_wdata;
    bit          unstable;

    initial for (int i = 0; i < 16; i++) rmem[i] = '0;

    always @(negedge clk) begin
        if (model_ack) begin
            model_ack = 1'b0;
            cnt = 0;
        end else if (rem_req) begin
            if (cnt == 0) begin
                seen_we = rem_we; seen_be = rem_be;
                seen_addr = rem_addr; seen_wdata = rem_wdata;
                unstable = 1'b0;
            end else if (seen_we !== rem_we || seen_be !== rem_be ||
                         seen_addr !== rem_addr || seen_wdata !== rem_wdata) begin
                unstable = 1'b1;
            end
            cnt++;
            if (cnt == rem_lat) begin
                if (rem_we)
                    for (int b = 0; b < 4; b++)
                        if (rem_be[b]) rmem[rem_addr[3:0]][8*b +: 8] = rem_wdata[8*b +: 8];
                rem_rdata = rmem[rem_addr[3:0]];
                model_ack = 1'b1;
                xfer_cnt++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [3:0] ofs, input logic [31:0] val);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = ofs; host_wdata = val;
        @(posedge clk);
        #1;
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input logic [3:0] ofs, output logic [31:0] val);
        @(negedge clk);
        host_addr = ofs;
        #1;
        val = host_rdata;
    endtask

    task automatic poll(output int bcyc);
        logic [31:0] v;
        bcyc = 0;
        for (int k = 0; k < 200; k++) begin
            host_read(4'h0, v);
            if (v[0]) bcyc++;
            else break;
        end
    endtask

    task automatic run_xfer(input logic [7:0] mode, input logic [31:0] addr,
                            input logic [31:0] data, input bit data_first, output int bcyc);
        if (data_first) begin
            host_write(4'hC, data); host_write(4'h8, addr);
        end else begin
            host_write(4'h8, addr); host_write(4'hC, data);
        end
        host_write(4'h4, {24'h0, mode});
        host_write(4'h0, 32'h1);
        poll(bcyc);
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    logic [31:0] exp_mem [16];
    logic [31:0] v;
    int          bc;
    int          x0;

    initial begin
        for (int i = 0; i < 16; i++) exp_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        for (int r = 0; r < 4; r++) begin
            host_read(4'(r * 4), v);
            chk("R1 reg after reset", v, 32'h0);
        end
        chk("R1 request idle", {31'h0, rem_req}, 32'h0);

        // R2 / R10: map, field widths, staging in any order starts nothing
        host_write(4'h8, 32'hDEAD1234);
        host_write(4'hC, 32'hCAFEF00D);
        host_write(4'h4, 32'hABCDEF31);
        host_read(4'h8, v); chk("R2 addr readback", v, 32'h00001234);
        host_read(4'hC, v); chk("R2 data readback", v, 32'hCAFEF00D);
        host_read(4'h4, v); chk("R2 mode readback", v, 32'h00000031);
        host_read(4'h0, v); chk("R10 staging starts nothing", v, 32'h0);
        chk("R10 no remote transfer", xfer_cnt, 32'h0);

        // R3: only the value 1 triggers
        host_write(4'h0, 32'h2);
        host_read(4'h0, v); chk("R3 ctrl=2 no start", v, 32'h0);
        host_write(4'h0, 32'h3);
        host_read(4'h0, v); chk("R3 ctrl=3 no start", v, 32'h0);
        repeat (20) @(negedge clk);
        chk("R3 no transfer issued", xfer_cnt, 32'h0);

        // sweep latency and address: full writes then reads
        for (int lat = 1; lat <= 16; lat++) begin
            rem_lat = lat;
            for (int a = 0; a < 16; a++) begin
                logic [31:0] wv, ad;
                wv = 32'h9E3779B9 * (lat * 16 + a + 1);
                ad = {16'hBEEF, 12'h123, 4'(a)};
                run_xfer(8'hF1, ad, wv, a[0], bc);
                exp_mem[a] = wv;
                chk("R4 write busy length", bc, lat);
                chk("R6 write flag", {31'h0, seen_we}, 32'h1);
                chk("R6 byte enables", {28'h0, seen_be}, 32'hF);
                chk("R6 remote addr", {16'h0, seen_addr}, {16'h0, 12'h123, 4'(a)});
                chk("R6 remote wdata", seen_wdata, wv);
                chk("R8 fields stable", {31'h0, unstable}, 32'h0);
                host_read(4'hC, v); chk("R6 data kept after write", v, wv);
            end
            for (int a = 0; a < 16; a++) begin
                run_xfer(8'h00, {16'h0, 12'h123, 4'(a)}, 32'h0, a[1], bc);
                chk("R4 read busy length", bc, lat);
                chk("R5 read flag", {31'h0, seen_we}, 32'h0);
                host_read(4'hC, v); chk("R5 read data captured", v, exp_mem[a]);
            end
        end

        // R6 partial writes, R5 byte enables ignored on read
        rem_lat = 3;
        run_xfer(8'h31, 32'h5, 32'h11223344, 1'b0, bc);
        exp_mem[5] = (exp_mem[5] & 32'hFFFF0000) | 32'h00003344;
        chk("R6 partial enables 0x31", {28'h0, seen_be}, 32'h3);
        run_xfer(8'hF0, 32'h5, 32'h0, 1'b1, bc);
        chk("R5 read drives no enables", {28'h0, seen_be}, 32'h0);
        host_read(4'hC, v); chk("R6 merge lanes 1:0", v, exp_mem[5]);
        run_xfer(8'h91, 32'h5, 32'hAABBCCDD, 1'b0, bc);
        exp_mem[5] = (exp_mem[5] & 32'h00FFFF00) | 32'hAA0000DD;
        run_xfer(8'h00, 32'h5, 32'h0, 1'b0, bc);
        host_read(4'hC, v); chk("R6 merge lanes 3 and 0", v, exp_mem[5]);

        // R7: host writes during busy are discarded
        rem_lat = 10;
        x0 = xfer_cnt;
        host_write(4'h8, 32'h7);
        host_write(4'hC, 32'h55AA55AA);
        host_write(4'h4, 32'hF1);
        host_write(4'h0, 32'h1);
        host_write(4'h4, 32'h0);
        host_write(4'h8, 32'h9);
        host_write(4'hC, 32'h0);
        host_write(4'h0, 32'h1);
        poll(bc);
        repeat (15) @(negedge clk);
        chk("R7 single transfer", xfer_cnt - x0, 32'h1);
        host_read(4'h4, v); chk("R7 mode kept", v, 32'hF1);
        host_read(4'h8, v); chk("R7 addr kept", v, 32'h7);
        host_read(4'hC, v); chk("R7 data kept", v, 32'h55AA55AA);
        chk("R7 remote wrote staged word", rmem[7], 32'h55AA55AA);
        chk("R8 fields stable under host writes", {31'h0, unstable}, 32'h0);

        // R9: stray acknowledge while idle
        host_write(4'hC, 32'h13579BDF);
        x0 = xfer_cnt;
        @(negedge clk); stray_ack = 1'b1;
        @(negedge clk); stray_ack = 1'b0;
        host_read(4'h0, v); chk("R9 ctrl idle after stray ack", v, 32'h0);
        host_read(4'hC, v); chk("R9 data untouched", v, 32'h13579BDF);
        chk("R9 no request", {31'h0, rem_req}, 32'h0);
        rem_lat = 4;
        run_xfer(8'h00, 32'h7, 32'h0, 1'b1, bc);
        chk("R4 latency after stray ack", bc, 32'd4);
        host_read(4'hC, v); chk("R5 read after stray ack", v, 32'h55AA55AA);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule